// File: doc/BRIEF.md
# Width-Packing Transfer Controller

This controller moves blocks of data between a 32-bit main-memory port and one of two local targets: a 64-bit frame buffer port and a 32-bit processing-array port. A host places one command on the command port. The command gives the direction, the target, a memory start address, a target start address and a length counted in target words. The controller then runs the transfer to its end and raises a one-cycle completion pulse.

Toward the buffer, two memory words are combined in a packing register to form each 64-bit buffer word. Toward the array, every memory word is passed straight through, so each array word costs one memory cycle. In the other direction, the controller reads a target word, holds it in the same register, and writes it back to memory as two halves (buffer) or as one word (array). It keeps three address streams: memory, buffer and array. Memory is reached through a valid/ready request port whose read data is valid in the handshake cycle. The buffer and array ports return read data one cycle after the read enable.

Top module: `dma_pack_ctrl`

## Requirements
- R1: While reset is held, and on the first cycle after it, `cmd_ready` is high, `done` is low, `mem_valid` is low and no buffer or array enable is high.
- R2: A command is taken only in a cycle where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high exactly when no transfer is running. A `cmd_valid` raised during a transfer has no effect on that transfer's addresses, data or length. Encodings: `cmd_dir` 0 moves memory into the target and 1 moves the target into memory; `cmd_dst` 0 selects the buffer and 1 selects the array.
- R3: Memory to buffer: each buffer word is built from two consecutive read beats. The first beat fills bits [31:0] and the second fills bits [63:32]. `buf_wr_en` is high in the cycle directly after the second beat.
- R4: Memory to array: each array word is written in the same cycle as its read beat, with `arr_wdata` equal to that cycle's `mem_rdata`. No array write occurs in a cycle without a read beat.
- R5: Buffer to memory: `buf_rd_en` is high for one cycle. The returned word is captured in the next cycle. It is then written as two memory beats: bits [31:0] first, then bits [63:32].
- R6: Array to memory: `arr_rd_en` is high for one cycle. The returned word is captured in the next cycle and written in a single memory beat.
- R7: The first memory beat uses `cmd_mem_addr`. The address rises by one after every completed beat (`mem_valid` and `mem_ready` both high). While `mem_valid` is high and `mem_ready` is low, the address, the write flag and the write data stay unchanged.
- R8: The first buffer or array access uses `cmd_dst_addr`. The target address rises by one per completed target word. At most one buffer or array enable is high in any cycle.
- R9: Exactly `cmd_len` target words are moved. `done` is high for a single cycle, one cycle after the last word's final access (buffer write, array write, or last memory write beat). For a zero-length command, `done` is high in the cycle after the command is taken. `cmd_ready` returns in the cycle after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Controller idle, command can be taken |
| cmd_dir | input | 1 | 0: memory into target, 1: target into memory |
| cmd_dst | input | 1 | 0: buffer, 1: array |
| cmd_mem_addr | input | MEM_AW | Memory start word address |
| cmd_dst_addr | input | DST_AW | Target start word address |
| cmd_len | input | LEN_W | Number of target words |
| done | output | 1 | One-cycle completion pulse |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | MEM_AW | Memory word address |
| mem_wdata | output | MEM_DW | Memory write data |
| mem_rdata | input | MEM_DW | Memory read data, valid in the handshake cycle |
| buf_wr_en | output | 1 | Buffer write enable |
| buf_rd_en | output | 1 | Buffer read enable |
| buf_addr | output | DST_AW | Buffer word address |
| buf_wdata | output | 2*MEM_DW | Buffer write data |
| buf_rdata | input | 2*MEM_DW | Buffer read data, one cycle after the enable |
| arr_wr_en | output | 1 | Array write enable |
| arr_rd_en | output | 1 | Array read enable |
| arr_addr | output | DST_AW | Array word address |
| arr_wdata | output | MEM_DW | Array write data |
| arr_rdata | input | MEM_DW | Array read data, one cycle after the enable |

## Verification
On the path from memory to the array, the memory read beat and the array write occur in the same cycle. A missing or extra array write appears only in cycles where the memory stalls. To provoke this, array-bound transfers are run against a memory whose `mem_ready` follows a pseudo-random pattern. The reference model then requires that each array write coincide with a beat, carry that beat's data and use the next target address. A second collision is a new command arriving while a transfer is still running. It is driven with differing fields during a stalled transfer and judged by the unchanged address streams and final contents.

// File: rtl/dma_pack_pkg.sv
package dma_pack_pkg;

   typedef enum logic [3:0] {
      ST_IDLE      = 4'd0,
      ST_LOAD_LO   = 4'd1,
      ST_LOAD_HI   = 4'd2,
      ST_WRITE_BUF = 4'd3,
      ST_XFER_ARR  = 4'd4,
      ST_RD_SRC    = 4'd5,
      ST_RD_CAP    = 4'd6,
      ST_STORE_LO  = 4'd7,
      ST_STORE_HI  = 4'd8,
      ST_DONE      = 4'd9
   } dma_state_e;

   localparam logic DIR_INTO_DST = 1'b0;
   localparam logic DIR_INTO_MEM = 1'b1;
   localparam logic DST_BUFFER   = 1'b0;
   localparam logic DST_ARRAY    = 1'b1;

   // advance strobes from the sequencer to the address generator
   typedef struct packed {
      logic load;       // command taken
      logic mem_step;   // memory beat completed
      logic word_step;  // target word completed
   } dma_step_t;

endpackage

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
   import dma_pack_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_valid,
   input  logic       cmd_dir,
   input  logic       cmd_dst,
   input  logic       cmd_len_zero,
   input  logic       mem_ready,
   input  logic       len_last,
   output dma_state_e state,
   output logic       dst_q,
   output dma_step_t  step
);

   dma_state_e nxt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         dst_q <= DST_BUFFER;
      end else begin
         state <= nxt;
         if (step.load) dst_q <= cmd_dst;
      end
   end

   always_comb begin
      nxt  = state;
      step = '0;
      case (state)
         ST_IDLE: begin
            if (cmd_valid) begin
               step.load = 1'b1;
               if (cmd_len_zero)               nxt = ST_DONE;
               else if (cmd_dir == DIR_INTO_MEM) nxt = ST_RD_SRC;
               else if (cmd_dst == DST_ARRAY)  nxt = ST_XFER_ARR;
               else                            nxt = ST_LOAD_LO;
            end
         end
         ST_LOAD_LO: begin
            if (mem_ready) begin
               step.mem_step = 1'b1;
               nxt = ST_LOAD_HI;
            end
         end
         ST_LOAD_HI: begin
            if (mem_ready) begin
               step.mem_step = 1'b1;
               nxt = ST_WRITE_BUF;
            end
         end
         ST_WRITE_BUF: begin
            step.word_step = 1'b1;
            nxt = len_last ? ST_DONE : ST_LOAD_LO;
         end
         ST_XFER_ARR: begin
            if (mem_ready) begin
               step.mem_step  = 1'b1;
               step.word_step = 1'b1;
               nxt = len_last ? ST_DONE : ST_XFER_ARR;
            end
         end
         ST_RD_SRC: nxt = ST_RD_CAP;
         ST_RD_CAP: nxt = ST_STORE_LO;
         ST_STORE_LO: begin
            if (mem_ready) begin
               step.mem_step = 1'b1;
               if (dst_q == DST_ARRAY) begin
                  step.word_step = 1'b1;
                  nxt = len_last ? ST_DONE : ST_RD_SRC;
               end else begin
                  nxt = ST_STORE_HI;
               end
            end
         end
         ST_STORE_HI: begin
            if (mem_ready) begin
               step.mem_step  = 1'b1;
               step.word_step = 1'b1;
               nxt = len_last ? ST_DONE : ST_RD_SRC;
            end
         end
         ST_DONE: nxt = ST_IDLE;
         default: nxt = ST_IDLE;
      endcase
   end

endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
   parameter int MEM_AW = 16,
   parameter int DST_AW = 8,
   parameter int LEN_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              run_sel,
   input  logic [MEM_AW-1:0] mem_start,
   input  logic [DST_AW-1:0] dst_start,
   input  logic [LEN_W-1:0]  len_start,
   input  logic              mem_step,
   input  logic              word_step,
   output logic [MEM_AW-1:0] mem_addr,
   output logic [DST_AW-1:0] buf_addr,
   output logic [DST_AW-1:0] arr_addr,
   output logic              len_last
);

   localparam int NUM_DST = 2;

   logic [DST_AW-1:0] ptr_q [NUM_DST];
   logic [LEN_W-1:0]  len_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        mem_addr <= '0;
      else if (load)     mem_addr <= mem_start;
      else if (mem_step) mem_addr <= mem_addr + MEM_AW'(1);
   end

   // one pointer per target; index 0 is the buffer, index 1 the array
   for (genvar g = 0; g < NUM_DST; g++) begin : g_dst
      localparam logic SEL = (g == 1);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                           ptr_q[g] <= '0;
         else if (load)                        ptr_q[g] <= dst_start;
         else if (word_step && run_sel == SEL) ptr_q[g] <= ptr_q[g] + DST_AW'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         len_q <= '0;
      else if (load)      len_q <= len_start;
      else if (word_step) len_q <= len_q - LEN_W'(1);
   end

   assign buf_addr = ptr_q[0];
   assign arr_addr = ptr_q[1];
   assign len_last = (len_q == LEN_W'(1));

endmodule

// File: rtl/dma_pack_reg.sv
module dma_pack_reg #(
   parameter int HALF_W     = 32,
   parameter bit PACK_RESET = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [1:0]          lane_we,
   input  logic [2*HALF_W-1:0] din,
   output logic [2*HALF_W-1:0] q
);

   // lane 0 holds the low half, lane 1 the high half
   for (genvar g = 0; g < 2; g++) begin : g_lane
      logic [HALF_W-1:0] lane_q;
      if (PACK_RESET) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          lane_q <= '0;
            else if (lane_we[g]) lane_q <= din[g*HALF_W +: HALF_W];
         end
      end else begin : g_nrst
         always_ff @(posedge clk) begin
            if (lane_we[g]) lane_q <= din[g*HALF_W +: HALF_W];
         end
      end
      assign q[g*HALF_W +: HALF_W] = lane_q;
   end

endmodule

// File: rtl/dma_pack_ctrl.sv
module dma_pack_ctrl
   import dma_pack_pkg::*;
#(
   parameter int MEM_DW     = 32,
   parameter int MEM_AW     = 16,
   parameter int DST_AW     = 8,
   parameter int LEN_W      = 8,
   parameter bit PACK_RESET = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cmd_valid,
   output logic                cmd_ready,
   input  logic                cmd_dir,
   input  logic                cmd_dst,
   input  logic [MEM_AW-1:0]   cmd_mem_addr,
   input  logic [DST_AW-1:0]   cmd_dst_addr,
   input  logic [LEN_W-1:0]    cmd_len,
   output logic                done,
   output logic                mem_valid,
   input  logic                mem_ready,
   output logic                mem_we,
   output logic [MEM_AW-1:0]   mem_addr,
   output logic [MEM_DW-1:0]   mem_wdata,
   input  logic [MEM_DW-1:0]   mem_rdata,
   output logic                buf_wr_en,
   output logic                buf_rd_en,
   output logic [DST_AW-1:0]   buf_addr,
   output logic [2*MEM_DW-1:0] buf_wdata,
   input  logic [2*MEM_DW-1:0] buf_rdata,
   output logic                arr_wr_en,
   output logic                arr_rd_en,
   output logic [DST_AW-1:0]   arr_addr,
   output logic [MEM_DW-1:0]   arr_wdata,
   input  logic [MEM_DW-1:0]   arr_rdata
);

   localparam int BUF_DW = 2 * MEM_DW;

   if (MEM_DW < 8 || (MEM_DW % 8) != 0) begin : g_bad_dw
      $error("MEM_DW must be a whole number of bytes");
   end
   if (LEN_W < 1 || DST_AW < 1 || MEM_AW < 1) begin : g_bad_w
      $error("address and length widths must be at least one bit");
   end

   dma_state_e        state;
   dma_step_t         step;
   logic              dst_q;
   logic              len_last;
   logic [1:0]        lane_we;
   logic [BUF_DW-1:0] pack_din;
   logic [BUF_DW-1:0] pack_q;

   dma_seq_fsm i_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .cmd_valid    (cmd_valid),
      .cmd_dir      (cmd_dir),
      .cmd_dst      (cmd_dst),
      .cmd_len_zero (cmd_len == '0),
      .mem_ready    (mem_ready),
      .len_last     (len_last),
      .state        (state),
      .dst_q        (dst_q),
      .step         (step)
   );

   dma_addr_gen #(
      .MEM_AW (MEM_AW),
      .DST_AW (DST_AW),
      .LEN_W  (LEN_W)
   ) i_agen (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (step.load),
      .run_sel   (dst_q),
      .mem_start (cmd_mem_addr),
      .dst_start (cmd_dst_addr),
      .len_start (cmd_len),
      .mem_step  (step.mem_step),
      .word_step (step.word_step),
      .mem_addr  (mem_addr),
      .buf_addr  (buf_addr),
      .arr_addr  (arr_addr),
      .len_last  (len_last)
   );

   // packing register lane selection per state
   always_comb begin
      lane_we  = 2'b00;
      pack_din = {mem_rdata, mem_rdata};
      case (state)
         ST_LOAD_LO: lane_we = {1'b0, mem_ready};
         ST_LOAD_HI: lane_we = {mem_ready, 1'b0};
         ST_RD_CAP: begin
            if (dst_q == DST_ARRAY) begin
               lane_we  = 2'b01;
               pack_din = {arr_rdata, arr_rdata};
            end else begin
               lane_we  = 2'b11;
               pack_din = buf_rdata;
            end
         end
         default: ;
      endcase
   end

   dma_pack_reg #(
      .HALF_W     (MEM_DW),
      .PACK_RESET (PACK_RESET)
   ) i_pack (
      .clk     (clk),
      .rst_n   (rst_n),
      .lane_we (lane_we),
      .din     (pack_din),
      .q       (pack_q)
   );

   assign cmd_ready = (state == ST_IDLE);
   assign done      = (state == ST_DONE);

   assign mem_valid = (state == ST_LOAD_LO)  || (state == ST_LOAD_HI) ||
                      (state == ST_XFER_ARR) || (state == ST_STORE_LO) ||
                      (state == ST_STORE_HI);
   assign mem_we    = (state == ST_STORE_LO) || (state == ST_STORE_HI);
   assign mem_wdata = (state == ST_STORE_HI) ? pack_q[BUF_DW-1:MEM_DW]
                                             : pack_q[MEM_DW-1:0];

   assign buf_wr_en = (state == ST_WRITE_BUF);
   assign buf_rd_en = (state == ST_RD_SRC) && (dst_q == DST_BUFFER);
   assign buf_wdata = pack_q;

   assign arr_wr_en = (state == ST_XFER_ARR) && mem_ready;
   assign arr_rd_en = (state == ST_RD_SRC) && (dst_q == DST_ARRAY);
   assign arr_wdata = mem_rdata;

endmodule

// File: rtl/dma_pack_ctrl_chk.sv
module dma_pack_ctrl_chk #(
   parameter int MEM_DW = 32,
   parameter int MEM_AW = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_ready,
   input logic              done,
   input logic              mem_valid,
   input logic              mem_ready,
   input logic              mem_we,
   input logic [MEM_AW-1:0] mem_addr,
   input logic [MEM_DW-1:0] mem_wdata,
   input logic              buf_wr_en,
   input logic              buf_rd_en,
   input logic              arr_wr_en,
   input logic              arr_rd_en
);

   a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |-> !(mem_valid || buf_wr_en || buf_rd_en || arr_wr_en || arr_rd_en || done));

   a_r3_buf_wr_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
      buf_wr_en |-> $past(mem_valid && mem_ready && !mem_we));

   a_r4_arr_wr_on_beat: assert property (@(posedge clk) disable iff (!rst_n)
      arr_wr_en |-> (mem_valid && mem_ready && !mem_we));

   // R5 and R6: the cycle after a target read only captures
   a_r5_capture_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_rd_en || arr_rd_en) |=> !(buf_rd_en || arr_rd_en || mem_valid));

   a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_ready) |=>
         (mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

   a_r7_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && mem_ready) |=> (!mem_valid || mem_addr == $past(mem_addr) + MEM_AW'(1)));

   a_r8_one_port: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({buf_wr_en, buf_rd_en, arr_wr_en, arr_rd_en}));

   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && cmd_ready));

endmodule

bind dma_pack_ctrl dma_pack_ctrl_chk #(
   .MEM_DW (MEM_DW),
   .MEM_AW (MEM_AW)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_ready (cmd_ready),
   .done      (done),
   .mem_valid (mem_valid),
   .mem_ready (mem_ready),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .buf_wr_en (buf_wr_en),
   .buf_rd_en (buf_rd_en),
   .arr_wr_en (arr_wr_en),
   .arr_rd_en (arr_rd_en)
);

// File: tb/test_dma_pack_ctrl.sv
module test_dma_pack_ctrl;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        cmd_valid, cmd_ready, cmd_dir, cmd_dst, done;
   logic [15:0] cmd_mem_addr;
   logic [7:0]  cmd_dst_addr, cmd_len;
   logic        mem_valid, mem_ready, mem_we;
   logic [15:0] mem_addr;
   logic [31:0] mem_wdata, mem_rdata;
   logic        buf_wr_en, buf_rd_en, arr_wr_en, arr_rd_en;
   logic [7:0]  buf_addr, arr_addr;
   logic [63:0] buf_wdata, buf_rdata;
   logic [31:0] arr_wdata, arr_rdata;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   dma_pack_ctrl i_dma_pack_ctrl (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_dir(cmd_dir), .cmd_dst(cmd_dst), .cmd_mem_addr(cmd_mem_addr),
      .cmd_dst_addr(cmd_dst_addr), .cmd_len(cmd_len), .done(done),
      .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .buf_wr_en(buf_wr_en), .buf_rd_en(buf_rd_en), .buf_addr(buf_addr),
      .buf_wdata(buf_wdata), .buf_rdata(buf_rdata), .arr_wr_en(arr_wr_en),
      .arr_rd_en(arr_rd_en), .arr_addr(arr_addr), .arr_wdata(arr_wdata),
      .arr_rdata(arr_rdata)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] mem_init(input int i);
      return {8'hC3, 8'(i), ~8'(i), 8'(i) ^ 8'h5A};
   endfunction
   function automatic logic [63:0] buf_init(input int i);
      return {8'hB0, 8'(i), 16'h1234, 8'h9E, ~8'(i), 8'(i * 3), 8'h77};
   endfunction
   function automatic logic [31:0] arr_init(input int i);
      return {8'hA1, 8'(i * 5), 8'h0F, ~8'(i)};
   endfunction

   // behavioural memory, buffer and array models
   logic [31:0] mem_model [0:255];
   logic [63:0] buf_store [0:255];
   logic [31:0] arr_store [0:255];
   logic        stall_en = 1'b0;
   logic [7:0]  lfsr = 8'h5B;

   initial begin
      for (int i = 0; i < 256; i++) begin
         mem_model[i] = mem_init(i);
         buf_store[i] = buf_init(i);
         arr_store[i] = arr_init(i);
      end
   end

   always @(posedge clk) lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
   assign mem_ready = !stall_en || lfsr[1];
   assign mem_rdata = mem_model[mem_addr[7:0]];

   always @(posedge clk) begin
      if (mem_valid && mem_ready && mem_we) mem_model[mem_addr[7:0]] <= mem_wdata;
      if (buf_wr_en) buf_store[buf_addr] <= buf_wdata;
      if (buf_rd_en) buf_rdata <= buf_store[buf_addr];
      if (arr_wr_en) arr_store[arr_addr] <= arr_wdata;
      if (arr_rd_en) arr_rdata <= arr_store[arr_addr];
   end

   // cycle-by-cycle reference model
   bit          act = 0, c_dir = 0, c_dst = 0, exp_done = 0, buf_pend = 0, half = 0;
   logic [15:0] exp_ma;
   logic [7:0]  exp_da;
   int          remaining;
   logic [31:0] lo_hold, hi_hold;

   always @(negedge clk) begin : ref_model
      bit nd, nb;
      nd = 0;
      nb = 0;
      if (rst_n) begin
         chk(done == exp_done, "R9 done timing", done, exp_done);
         chk(cmd_ready == !act, "R2 ready only when idle", cmd_ready, !act);
         if (!act)
            chk(!(mem_valid || buf_wr_en || buf_rd_en || arr_wr_en || arr_rd_en),
                "R2 idle quiet", {mem_valid, buf_wr_en, buf_rd_en, arr_wr_en, arr_rd_en}, 0);
         if (done) act = 0;
         if (cmd_valid && cmd_ready) begin
            act = 1; c_dir = cmd_dir; c_dst = cmd_dst;
            exp_ma = cmd_mem_addr; exp_da = cmd_dst_addr;
            remaining = cmd_len; half = 0;
            if (cmd_len == 0) nd = 1;
         end
         if (mem_valid && mem_ready) begin
            chk(mem_addr == exp_ma, "R7 memory address", mem_addr, exp_ma);
            chk(mem_we == c_dir, "R5 beat direction", mem_we, c_dir);
            exp_ma = exp_ma + 16'd1;
            if (!c_dir && !c_dst) begin
               if (!half) begin lo_hold = mem_rdata; half = 1; end
               else begin hi_hold = mem_rdata; half = 0; nb = 1; end
            end else if (!c_dir && c_dst) begin
               chk(arr_wr_en && arr_wdata == mem_rdata, "R4 array write with beat", arr_wdata, mem_rdata);
               chk(arr_addr == exp_da, "R8 array address", arr_addr, exp_da);
               exp_da = exp_da + 8'd1; remaining--;
               if (remaining == 0) nd = 1;
            end else if (c_dst || half) begin
               exp_da = exp_da + 8'd1; remaining--; half = 0;
               if (remaining == 0) nd = 1;
            end else begin
               half = 1;
            end
         end else begin
            chk(!arr_wr_en, "R4 no array write without beat", arr_wr_en, 0);
         end
         if (buf_wr_en) begin
            chk(buf_pend, "R3 buffer write follows second beat", 0, 1);
            chk(buf_wdata == {hi_hold, lo_hold}, "R3 packed order", buf_wdata, {hi_hold, lo_hold});
            chk(buf_addr == exp_da, "R8 buffer address", buf_addr, exp_da);
            exp_da = exp_da + 8'd1; remaining--;
            if (remaining == 0) nd = 1;
         end else begin
            chk(!buf_pend, "R3 buffer write missing", buf_wr_en, 1);
         end
         if (buf_rd_en) chk(buf_addr == exp_da, "R8 buffer read address", buf_addr, exp_da);
         if (arr_rd_en) chk(arr_addr == exp_da, "R8 array read address", arr_addr, exp_da);
         buf_pend = nb;
         exp_done = nd;
      end
   end

   task automatic run(input bit dir, input bit dst, input int ma, input int da, input int len, input bit junk);
      @(posedge clk); #1;
      while (!cmd_ready) begin @(posedge clk); #1; end
      cmd_valid = 1; cmd_dir = dir; cmd_dst = dst;
      cmd_mem_addr = 16'(ma); cmd_dst_addr = 8'(da); cmd_len = 8'(len);
      @(posedge clk); #1;
      if (junk) begin
         // R2: a second command while busy must be ignored
         cmd_dir = ~dir; cmd_dst = ~dst; cmd_mem_addr = 16'h00F0;
         cmd_dst_addr = 8'hF0; cmd_len = 8'd9;
         repeat (3) begin @(posedge clk); #1; end
      end
      cmd_valid = 0;
      do @(negedge clk); while (!done);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL R9 watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 0; cmd_valid = 0; cmd_dir = 0; cmd_dst = 0;
      cmd_mem_addr = '0; cmd_dst_addr = '0; cmd_len = '0;
      repeat (3) @(negedge clk);
      chk(cmd_ready && !done && !mem_valid && !(buf_wr_en || buf_rd_en || arr_wr_en || arr_rd_en),
          "R1 reset state", {cmd_ready, done, mem_valid, buf_wr_en, buf_rd_en, arr_wr_en, arr_rd_en}, 64'h40);
      @(posedge clk); #1 rst_n = 1;
      @(negedge clk);
      chk(cmd_ready && !done && !mem_valid, "R1 first cycle after reset", {cmd_ready, done, mem_valid}, 3'b100);

      // memory into buffer, no stall then stalled (R3)
      run(0, 0, 16'h00, 8'h10, 3, 0);
      for (int k = 0; k < 3; k++)
         chk(buf_store[8'h10 + k] == {mem_model[2*k + 1], mem_model[2*k]}, "R3 buffer content",
             buf_store[8'h10 + k], {mem_model[2*k + 1], mem_model[2*k]});
      chk(buf_store[8'h13] == buf_init(8'h13), "R9 no word past length", buf_store[8'h13], buf_init(8'h13));
      stall_en = 1;
      run(0, 0, 16'h08, 8'h20, 4, 0);
      for (int k = 0; k < 4; k++)
         chk(buf_store[8'h20 + k] == {mem_model[8 + 2*k + 1], mem_model[8 + 2*k]}, "R3 stalled buffer content",
             buf_store[8'h20 + k], {mem_model[8 + 2*k + 1], mem_model[8 + 2*k]});

      // memory into array, stalled with a command arriving while busy (R4, R2)
      run(0, 1, 16'h20, 8'h10, 6, 1);
      for (int k = 0; k < 6; k++)
         chk(arr_store[8'h10 + k] == mem_model[8'h20 + k], "R4 array content",
             arr_store[8'h10 + k], mem_model[8'h20 + k]);
      chk(arr_store[8'h16] == arr_init(8'h16), "R2 busy command ignored", arr_store[8'h16], arr_init(8'h16));
      chk(mem_model[8'hF0] == mem_init(8'hF0), "R2 busy command ignored mem", mem_model[8'hF0], mem_init(8'hF0));

      // back to back: array fill then buffer to memory (R5)
      stall_en = 0;
      run(0, 1, 16'h30, 8'h30, 2, 0);
      stall_en = 1;
      run(1, 0, 16'h80, 8'h40, 3, 0);
      for (int k = 0; k < 3; k++) begin
         chk(mem_model[8'h80 + 2*k] == buf_store[8'h40 + k][31:0], "R5 low half first",
             mem_model[8'h80 + 2*k], buf_store[8'h40 + k][31:0]);
         chk(mem_model[8'h81 + 2*k] == buf_store[8'h40 + k][63:32], "R5 high half second",
             mem_model[8'h81 + 2*k], buf_store[8'h40 + k][63:32]);
      end
      chk(mem_model[8'h86] == mem_init(8'h86), "R9 memory past length", mem_model[8'h86], mem_init(8'h86));

      // array to memory (R6)
      run(1, 1, 16'h90, 8'h50, 4, 0);
      for (int k = 0; k < 4; k++)
         chk(mem_model[8'h90 + k] == arr_store[8'h50 + k], "R6 array to memory",
             mem_model[8'h90 + k], arr_store[8'h50 + k]);

      // zero length (R9)
      run(0, 0, 16'hA0, 8'h60, 0, 0);
      chk(buf_store[8'h60] == buf_init(8'h60), "R9 zero length moves nothing", buf_store[8'h60], buf_init(8'h60));

      repeat (3) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule